// File: doc/BRIEF.md
# Sleep-State Wake Qualifier

This block watches two wake sources while its host sits in a low-power sleep state. It emits a one-cycle request pulse for each source only when that source shows a valid wake pattern. The first source is the receive level of a single-wire vehicle bus, where low means dominant. A bus request needs three things in turn: the bus falls, stays dominant for at least the bus filter time, and then returns to recessive. The request is issued on that closing return, never while the bus is still dominant. The second source is an active-low local wake pin. A local request needs the pin to fall and then stay low for the local filter time. The request fires while the pin is still low.

Both inputs are asynchronous. Each one passes through a two-flop synchroniser before any edge detection. Filter times are parameters counted in clock cycles, so the integrator scales them from the wanted microsecond windows. The bus window is typically 90 µs and the local window typically 35 µs. The local pin has to re-arm before it can wake the device again: it must stay high for a minimum number of cycles before its next fall counts. A pin that is stuck low therefore cannot produce repeated wakes. Both qualifiers do their work only while the sleep indicator is high, and they drop any partial progress as soon as it goes low.

Top module: `wake_filter`

## Requirements
- R1: While `sleep_i` is low, neither output pulses in the following cycle, whatever the inputs do.
- R2: Each pin is sampled through two flops. A bus wake pulse is high in the cycle after the third rising clock edge that samples the bus back at 1. A local wake pulse is high in the cycle after the edge that sees the LOC_FILT_CYC-th synchronised low sample.
- R3: During sleep, if `bus_rx_i` falls to 0, stays 0 for at least BUS_FILT_CYC sampling edges and then returns to 1, `bus_wake_o` pulses exactly once.
- R4: During sleep, a dominant run of fewer than BUS_FILT_CYC samples produces no bus wake, and the next fall starts a fresh count.
- R5: Each asserted pulse on `bus_wake_o` or `loc_wake_o` lasts exactly one cycle.
- R6: During sleep, if an armed `wake_n_i` falls and stays 0 for LOC_FILT_CYC samples, `loc_wake_o` pulses once, while the pin is still low.
- R7: During sleep, a low run on `wake_n_i` shorter than LOC_FILT_CYC samples produces no local wake.
- R8: A fall on `wake_n_i` counts only if the pin was high for at least LOC_REARM_CYC synchronised samples just before it, with that high counted during sleep. So a pin held low gives at most one wake, and a pin that is already low when sleep starts gives none.
- R9: Dropping `sleep_i` discards a bus or local qualification in progress, so a later return to sleep does not complete it.
- R10: A bus that is already dominant when sleep starts yields no bus wake when it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High while the host is in sleep; enables both qualifiers |
| bus_rx_i | input | 1 | Bus receive level, 0 = dominant, asynchronous |
| wake_n_i | input | 1 | Local wake pin, active low, asynchronous |
| bus_wake_o | output | 1 | One-cycle qualified bus wake request |
| loc_wake_o | output | 1 | One-cycle qualified local wake request |

## Verification
The bus input is driven with dominant runs exactly at the filter length, one cycle short and well over it. This separates an off-by-one filter from a correct one. Bursts of short glitches and a dominant that is already present at sleep entry show that only a genuine falling edge followed by a long run is accepted. The local pin gets a run at its threshold, a run one cycle short, a long stuck-low hold, and re-arm highs just under and exactly at their minimum. Together these distinguish a single wake from repeated wakes and a missing re-arm from a present one. Sleep is also dropped in the middle of a dominant run, which shows whether progress is cleared or carried over.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  // Saturating increment: counts up to lim and stays there.
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

  // True once a run length has reached its threshold.
  function automatic logic reached(input logic [31:0] v, input logic [31:0] lim);
    return v >= lim;
  endfunction
endpackage

// File: rtl/wkf_sync2.sv
module wkf_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wkf_bus_qual.sv
module wkf_bus_qual
  import wkf_pkg::*;
#(
  parameter int FILT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic lvl,
  output logic wake
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          prev;
  logic          active;
  logic [CW-1:0] cnt;
  logic          fall_ev;
  logic          rise_ev;
  logic          long_enough;

  assign fall_ev     = prev & ~lvl;
  assign rise_ev     = ~prev & lvl;
  assign long_enough = reached(32'(cnt), 32'(FILT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      wake   <= 1'b0;
    end else if (!sleep) begin
      active <= 1'b0;
      cnt    <= '0;
      wake   <= 1'b0;
    end else begin
      wake <= rise_ev & active & long_enough;
      if (fall_ev) begin
        active <= 1'b1;
        cnt    <= CW'(1);
      end else if (active && !lvl) begin
        cnt <= CW'(sat_inc(32'(cnt), 32'(FILT_CYC)));
      end else if (rise_ev) begin
        active <= 1'b0;
        cnt    <= '0;
      end
    end
  end

  p_bus_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(rise_ev));
  p_bus_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && active && !long_enough) |=> !wake);
  p_bus_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  p_bus_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (!active && !wake));
endmodule

// File: rtl/wkf_local_qual.sv
module wkf_local_qual
  import wkf_pkg::*;
#(
  parameter int FILT_CYC  = 8,
  parameter int REARM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic lvl,
  output logic wake
);
  localparam int LW = $clog2(FILT_CYC + 1);
  localparam int HW = $clog2(REARM_CYC + 1);

  logic          prev;
  logic          active;
  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic          fall_ev;
  logic          armed;
  logic          start;
  logic          cont;
  logic          hit;
  logic [31:0]   nxt_lo;

  assign fall_ev = prev & ~lvl;
  assign armed   = reached(32'(hi_cnt), 32'(REARM_CYC));
  assign start   = fall_ev & armed;
  assign cont    = active & ~lvl;
  assign nxt_lo  = fall_ev ? 32'd1 : sat_inc(32'(lo_cnt), 32'(FILT_CYC));
  assign hit     = (start | cont) & reached(nxt_lo, 32'(FILT_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lo_cnt <= '0;
      hi_cnt <= '0;
      wake   <= 1'b0;
    end else if (!sleep) begin
      active <= 1'b0;
      lo_cnt <= '0;
      hi_cnt <= '0;
      wake   <= 1'b0;
    end else begin
      wake   <= hit;
      hi_cnt <= lvl ? HW'(sat_inc(32'(hi_cnt), 32'(REARM_CYC))) : '0;
      if (start || cont) begin
        active <= ~hit;
        lo_cnt <= LW'(nxt_lo);
      end else begin
        active <= 1'b0;
        lo_cnt <= '0;
      end
    end
  end

  p_loc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);
  p_loc_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !$past(lvl));
  p_loc_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && fall_ev && !armed) |=> (!active && !wake));
  p_loc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep |=> (!active && !wake));
endmodule

// File: rtl/wake_filter.sv
module wake_filter #(
  parameter int BUS_FILT_CYC  = 20,
  parameter int LOC_FILT_CYC  = 8,
  parameter int LOC_REARM_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic bus_rx_i,
  input  logic wake_n_i,
  output logic bus_wake_o,
  output logic loc_wake_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] synced;

  assign raw = {wake_n_i, bus_rx_i};

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_sync
      wkf_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw[g]),
        .q    (synced[g])
      );
    end
  endgenerate

  wkf_bus_qual #(.FILT_CYC(BUS_FILT_CYC)) u_bus (
    .clk  (clk),
    .rst_n(rst_n),
    .sleep(sleep_i),
    .lvl  (synced[0]),
    .wake (bus_wake_o)
  );

  wkf_local_qual #(.FILT_CYC(LOC_FILT_CYC), .REARM_CYC(LOC_REARM_CYC)) u_loc (
    .clk  (clk),
    .rst_n(rst_n),
    .sleep(sleep_i),
    .lvl  (synced[1]),
    .wake (loc_wake_o)
  );

  p_quiet_awake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |=> (!bus_wake_o && !loc_wake_o));
endmodule

// File: tb/sim_wake_filter.sv
`timescale 1ns/1ps
module sim_wake_filter;
  localparam int BUS = 20;
  localparam int LOC = 8;
  localparam int ARM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0;
  logic bus_rx_i = 1'b1;
  logic wake_n_i = 1'b1;
  logic bus_wake_o, loc_wake_o;

  int vectors = 0;
  int fails = 0;
  int bw_cnt = 0;
  int lw_cnt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  wake_filter #(.BUS_FILT_CYC(BUS), .LOC_FILT_CYC(LOC), .LOC_REARM_CYC(ARM)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .bus_rx_i(bus_rx_i),
    .wake_n_i(wake_n_i), .bus_wake_o(bus_wake_o), .loc_wake_o(loc_wake_o)
  );

  // Behavioural reference: pin histories and run-length integers.
  bit bh[3];
  bit wh[3];
  int b_run, l_lo, l_hi;
  bit b_trk, l_trk, e_bw, e_lw;

  always @(posedge clk) begin
    bit bc, bp, lc, lp;
    if (!rst_n) begin
      foreach (bh[i]) begin bh[i] = 1'b1; wh[i] = 1'b1; end
      b_run = 0; l_lo = 0; l_hi = 0;
      b_trk = 0; l_trk = 0; e_bw = 0; e_lw = 0;
    end else begin
      bc = bh[1]; bp = bh[2];
      lc = wh[1]; lp = wh[2];
      if (!sleep_i) begin
        b_run = 0; b_trk = 0; e_bw = 0;
        l_lo = 0; l_hi = 0; l_trk = 0; e_lw = 0;
      end else begin
        e_bw = 0;
        if (bp && !bc) begin b_trk = 1; b_run = 1; end
        else if (b_trk && !bc) b_run++;
        else if (b_trk && bc) begin e_bw = (b_run >= BUS); b_trk = 0; end
        e_lw = 0;
        if (lp && !lc && l_hi >= ARM) begin
          l_trk = 1; l_lo = 1;
          if (l_lo >= LOC) begin e_lw = 1; l_trk = 0; end
        end else if (l_trk && !lc) begin
          l_lo++;
          if (l_lo >= LOC) begin e_lw = 1; l_trk = 0; end
        end else l_trk = 0;
        l_hi = lc ? l_hi + 1 : 0;
      end
      bh[2] = bh[1]; bh[1] = bh[0]; bh[0] = bus_rx_i;
      wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = wake_n_i;
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (bus_wake_o !== e_bw) begin
        fails++;
        $display("FAIL R2/R3/R4/R5 bus_wake_o actual %b expected %b at cycle %0d", bus_wake_o, e_bw, cyc);
      end
      if (loc_wake_o !== e_lw) begin
        fails++;
        $display("FAIL R2/R6/R7/R8 loc_wake_o actual %b expected %b at cycle %0d", loc_wake_o, e_lw, cyc);
      end
      if (bus_wake_o) bw_cnt++;
      if (loc_wake_o) lw_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog (all) actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s pulse count actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_low(input int n);
    bus_rx_i = 1'b0; wait_n(n); bus_rx_i = 1'b1;
  endtask

  task automatic pin_low(input int n);
    wake_n_i = 1'b0; wait_n(n); wake_n_i = 1'b1;
  endtask

  initial begin
    int b0, l0;
    wait_n(3);
    vectors++;
    if (bus_wake_o !== 1'b0 || loc_wake_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b%b expected 00", bus_wake_o, loc_wake_o);
    end
    rst_n = 1'b1; wait_n(4);

    // R1: awake, valid-looking patterns ignored
    b0 = bw_cnt; l0 = lw_cnt;
    bus_low(30); pin_low(20); wait_n(8);
    chk("R1 bus", bw_cnt - b0, 0); chk("R1 local", lw_cnt - l0, 0);

    sleep_i = 1'b1; wait_n(8);
    // R3: exact threshold
    b0 = bw_cnt; bus_low(BUS); wait_n(8); chk("R3 exact", bw_cnt - b0, 1);
    // R4: one short
    b0 = bw_cnt; bus_low(BUS - 1); wait_n(8); chk("R4 short", bw_cnt - b0, 0);
    // R3 long run, R5 single pulse
    b0 = bw_cnt; bus_low(45); wait_n(8); chk("R3/R5 long", bw_cnt - b0, 1);
    // R4: glitch burst
    b0 = bw_cnt;
    for (int i = 0; i < 6; i++) begin bus_low(3); wait_n(2); end
    wait_n(8); chk("R4 glitches", bw_cnt - b0, 0);

    // R6 exact local threshold
    l0 = lw_cnt; pin_low(LOC); wait_n(8); chk("R6 exact", lw_cnt - l0, 1);
    // R7 one short
    l0 = lw_cnt; pin_low(LOC - 1); wait_n(8); chk("R7 short", lw_cnt - l0, 0);
    // R8 stuck low: one wake only, short re-arm ignored
    l0 = lw_cnt; wake_n_i = 1'b0; wait_n(60);
    wake_n_i = 1'b1; wait_n(ARM - 1); wake_n_i = 1'b0; wait_n(20);
    chk("R8 stuck low", lw_cnt - l0, 1);
    // R8 re-arm at exact minimum
    l0 = lw_cnt; wake_n_i = 1'b1; wait_n(ARM); pin_low(LOC + 2); wait_n(8);
    chk("R8 rearm", lw_cnt - l0, 1);

    // R9: sleep dropped during dominant run
    b0 = bw_cnt; bus_rx_i = 1'b0; wait_n(10);
    sleep_i = 1'b0; wait_n(2); sleep_i = 1'b1; wait_n(25); bus_rx_i = 1'b1; wait_n(8);
    chk("R9 bus", bw_cnt - b0, 0);

    // R8/R10: sources already low at sleep entry
    sleep_i = 1'b0; wait_n(4);
    b0 = bw_cnt; l0 = lw_cnt;
    bus_rx_i = 1'b0; wake_n_i = 1'b0; wait_n(6);
    sleep_i = 1'b1; wait_n(30);
    bus_rx_i = 1'b1; wait_n(30);
    chk("R10 bus", bw_cnt - b0, 0); chk("R8 entry low", lw_cnt - l0, 0);
    wake_n_i = 1'b1; wait_n(8);

    // Both sources together after recovery
    b0 = bw_cnt; l0 = lw_cnt;
    bus_rx_i = 1'b0; wake_n_i = 1'b0; wait_n(BUS + 2);
    bus_rx_i = 1'b1; wake_n_i = 1'b1; wait_n(8);
    chk("R3 both", bw_cnt - b0, 1); chk("R6 both", lw_cnt - l0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule